// File: doc/BRIEF.md
# Seven-Level Priority Interrupt Controller

This block decides which device interrupt the processor serves next. Every device carries a 3-bit level code. Codes 1 to 7 are priority levels, with 1 the most urgent. Code 0 switches the device's interrupts off. The processor signals each memory-read point of its instruction cycle. At such a point the controller may start an interrupt: it pulses a take strobe and gives the address of the level's first vector location.

The processor executes the word at that first location and reports the outcome back. If the word was a block-transfer instruction whose incremented count is still nonzero, the controller dismisses the level at once. This gives cheap, handler-free data movement. Otherwise the controller sends the processor on to the second vector location, where the real handler starts.

A level stays in service until software dismisses it. Only a strictly more urgent level can interrupt it, and interrupts nest this way. A status word shows which levels are requesting and which are in service.

Top module: `pic7_ctrl`

## Requirements
- R1: A write with `lvl_wr_en` high stores the 3-bit `lvl_wr_code` as the level of device `lvl_wr_dev`. The new level governs that device's requests from the next clock cycle on.
- R2: A device whose level code is 0 never causes an interrupt and never shows as requesting, even while its request input is high.
- R3: When several levels request at once, the lowest nonzero level number is taken first.
- R4: An interrupt is taken only in a cycle where `mem_rd_pt` is high. One cycle later `take` pulses for one cycle, `take_level` shows the level, and `vec_addr` equals VEC_BASE + 2*level (default VEC_BASE = 40).
- R5: While levels are in service, a request is taken only if its level number is strictly smaller than the smallest level number in service. The same level and less urgent levels wait.
- R6: A `dismiss` pulse clears only the in-service level with the smallest number.
- R7: After a take, the controller waits for `first_done`. If `first_blk_nz` is high with it, the level leaves service in the next cycle and `hnd_go` stays low.
- R8: If `first_done` arrives with `first_blk_nz` low, `hnd_go` pulses one cycle later with `vec_addr` = VEC_BASE + 2*level + 1, and the level stays in service.
- R9: `status[L-1]` is high when some device at level L requests. `status[L+6]` is high when level L is in service (L = 1..7).
- R10: After reset every device has level 0, no level is in service, and `take` and `hnd_go` are low.
- R11: Requests are level-sensitive. A request not yet served, or served and then dismissed, is taken at a later read point for as long as the device holds it high.
- R12: While waiting for `first_done`, `mem_rd_pt` and `dismiss` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | N_DEV | Per-device interrupt request, level-sensitive |
| lvl_wr_en | input | 1 | Level assignment write strobe |
| lvl_wr_dev | input | DEV_W | Device index for the level write |
| lvl_wr_code | input | 3 | Level code written (0 = disabled) |
| mem_rd_pt | input | 1 | Processor is at a memory-read point |
| first_done | input | 1 | Processor finished the first vector word |
| first_blk_nz | input | 1 | That word was a block transfer leaving a nonzero count |
| dismiss | input | 1 | Software dismisses the most urgent in-service level |
| take | output | 1 | Interrupt taken this cycle |
| take_level | output | 3 | Level of the most recent take |
| hnd_go | output | 1 | Go to the handler entry at the second vector location |
| vec_addr | output | ADDR_W | Vector address for take or hnd_go |
| status | output | 14 | Requesting levels [6:0], in-service levels [13:7] |

## Verification
The assertions check several properties on every cycle:
- A take never names level 0, and it never names a level at or below an in-service level.
- `take` and `hnd_go` never pulse together.
- A handler jump follows only a wait for the first-word outcome.
- A nonzero block result always removes its level from service.

Other behaviours can only be shown by the bench's directed scenarios:
- the choice among simultaneous requests;
- the exact vector addresses;
- nesting, and dismiss order across nested levels;
- level reassignment and disabling;
- a still-held request coming back after a dismiss.

// File: rtl/pic7_pkg.sv
package pic7_pkg;

    localparam int LVL_W = 3;
    localparam int NLVL  = 8;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [NLVL-1:0]  lvlmask_t;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } seq_st_t;

    typedef struct packed {
        logic vld;
        lvl_t lvl;
    } grant_t;

    // isolate the least significant set bit (most urgent level)
    function automatic lvlmask_t low_onehot(lvlmask_t m);
        return m & (~m + lvlmask_t'(1));
    endfunction

    function automatic lvl_t oh2idx(lvlmask_t oh);
        lvl_t r;
        r = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (oh[i]) r = lvl_t'(i);
        end
        return r;
    endfunction

    // levels strictly more urgent than l (numbers 1 .. l-1)
    function automatic lvlmask_t above_mask(lvl_t l);
        lvlmask_t r;
        r = '0;
        for (int i = 1; i < NLVL; i++) begin
            if (lvl_t'(i) < l) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/pic7_lvl_table.sv
module pic7_lvl_table
    import pic7_pkg::*;
#(
    parameter int N_DEV = 8,
    parameter int DEV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DEV_W-1:0] wr_dev,
    input  lvl_t             wr_code,
    input  logic [N_DEV-1:0] dev_req,
    output lvlmask_t         lvl_req
);

    lvl_t lvl_q [N_DEV];

    for (genvar d = 0; d < N_DEV; d++) begin : g_dev
        always_ff @(posedge clk) begin
            if (rst)
                lvl_q[d] <= '0;
            else if (wr_en && (wr_dev == DEV_W'(d)))
                lvl_q[d] <= wr_code;
        end
    end

    always_comb begin
        lvl_req = '0;
        for (int d = 0; d < N_DEV; d++) begin
            if (dev_req[d]) lvl_req[lvl_q[d]] = 1'b1;
        end
        lvl_req[0] = 1'b0;   // code 0: interrupts disabled
    end

endmodule

// File: rtl/pic7_arb.sv
module pic7_arb
    import pic7_pkg::*;
(
    input  lvlmask_t lvl_req,
    input  lvlmask_t act,
    output grant_t   grant
);

    lvlmask_t ceil_mask;
    lvlmask_t elig;

    always_comb begin
        if (act == '0)
            ceil_mask = lvlmask_t'({NLVL{1'b1}}) & ~lvlmask_t'(1);
        else
            ceil_mask = above_mask(oh2idx(low_onehot(act)));
        elig      = lvl_req & ceil_mask;
        grant.vld = |elig;
        grant.lvl = oh2idx(low_onehot(elig));
    end

endmodule

// File: rtl/pic7_seq.sv
module pic7_seq
    import pic7_pkg::*;
#(
    parameter int VEC_BASE = 40,
    parameter int ADDR_W   = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_rd_pt,
    input  grant_t            grant,
    input  logic              dismiss,
    input  logic              first_done,
    input  logic              first_blk_nz,
    output logic              take,
    output lvl_t              take_level,
    output logic              hnd_go,
    output logic [ADDR_W-1:0] vec_addr,
    output lvlmask_t          act
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VEC_BASE);

    seq_st_t           st_q, st_d;
    lvlmask_t          act_q, act_d;
    lvl_t              cur_q, cur_d;
    logic              take_d, hnd_d;
    logic [ADDR_W-1:0] vec_q, vec_d;

    always_comb begin
        st_d   = st_q;
        act_d  = act_q;
        cur_d  = cur_q;
        vec_d  = vec_q;
        take_d = 1'b0;
        hnd_d  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (dismiss) act_d = act_d & ~low_onehot(act_q);
                if (mem_rd_pt && grant.vld) begin
                    act_d         = act_d | (lvlmask_t'(1) << grant.lvl);
                    cur_d         = grant.lvl;
                    vec_d         = BASE + ADDR_W'({grant.lvl, 1'b0});
                    take_d        = 1'b1;
                    st_d          = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (first_done) begin
                    st_d = ST_IDLE;
                    if (first_blk_nz) begin
                        act_d = act_q & ~(lvlmask_t'(1) << cur_q);
                    end else begin
                        hnd_d = 1'b1;
                        vec_d = BASE + ADDR_W'({cur_q, 1'b1});
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            act_q  <= '0;
            cur_q  <= '0;
            vec_q  <= '0;
            take   <= 1'b0;
            hnd_go <= 1'b0;
        end else begin
            st_q   <= st_d;
            act_q  <= act_d;
            cur_q  <= cur_d;
            vec_q  <= vec_d;
            take   <= take_d;
            hnd_go <= hnd_d;
        end
    end

    assign take_level = cur_q;
    assign vec_addr   = vec_q;
    assign act        = act_q;

    // R2 / R4: a take never names the disabled code
    a_r4_take_level_nonzero: assert property (@(posedge clk) disable iff (rst)
        take |-> (cur_q != '0));

    // R5: nothing more urgent than the taken level was in service
    a_r5_take_is_most_urgent: assert property (@(posedge clk) disable iff (rst)
        take |-> ((act_q & above_mask(cur_q)) == '0));

    // R7: nonzero block result removes the level from service
    a_r7_fast_dismiss: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && first_done && first_blk_nz) |=> (act_q[cur_q] == 1'b0 && !hnd_go));

    // R8: take and handler jump never coincide
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(take && hnd_go));

    // R8: handler jump only follows a wait for the first word
    a_r8_hnd_after_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(hnd_go) |-> $past(st_q == ST_WAIT));

endmodule

// File: rtl/pic7_ctrl.sv
module pic7_ctrl
    import pic7_pkg::*;
#(
    parameter int N_DEV    = 8,
    parameter int VEC_BASE = 40,
    parameter int ADDR_W   = 18,
    localparam int DEV_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_DEV-1:0]  dev_req,
    input  logic              lvl_wr_en,
    input  logic [DEV_W-1:0]  lvl_wr_dev,
    input  logic [2:0]        lvl_wr_code,
    input  logic              mem_rd_pt,
    input  logic              first_done,
    input  logic              first_blk_nz,
    input  logic              dismiss,
    output logic              take,
    output logic [2:0]        take_level,
    output logic              hnd_go,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [13:0]       status
);

    lvlmask_t lvl_req;
    lvlmask_t act;
    grant_t   grant;

    pic7_lvl_table #(.N_DEV(N_DEV), .DEV_W(DEV_W)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lvl_wr_en),
        .wr_dev  (lvl_wr_dev),
        .wr_code (lvl_wr_code),
        .dev_req (dev_req),
        .lvl_req (lvl_req)
    );

    pic7_arb u_arb (
        .lvl_req (lvl_req),
        .act     (act),
        .grant   (grant)
    );

    pic7_seq #(.VEC_BASE(VEC_BASE), .ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .mem_rd_pt    (mem_rd_pt),
        .grant        (grant),
        .dismiss      (dismiss),
        .first_done   (first_done),
        .first_blk_nz (first_blk_nz),
        .take         (take),
        .take_level   (take_level),
        .hnd_go       (hnd_go),
        .vec_addr     (vec_addr),
        .act          (act)
    );

    assign status = {act[7:1], lvl_req[7:1]};

endmodule

// File: tb/tb_pic7_ctrl.sv
module tb_pic7_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  dev_req = '0;
    logic        lvl_wr_en = 1'b0;
    logic [2:0]  lvl_wr_dev = '0;
    logic [2:0]  lvl_wr_code = '0;
    logic        mem_rd_pt = 1'b0;
    logic        first_done = 1'b0;
    logic        first_blk_nz = 1'b0;
    logic        dismiss = 1'b0;
    logic        take;
    logic [2:0]  take_level;
    logic        hnd_go;
    logic [17:0] vec_addr;
    logic [13:0] status;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pic7_ctrl dut (
        .clk(clk), .rst(rst), .dev_req(dev_req),
        .lvl_wr_en(lvl_wr_en), .lvl_wr_dev(lvl_wr_dev), .lvl_wr_code(lvl_wr_code),
        .mem_rd_pt(mem_rd_pt), .first_done(first_done), .first_blk_nz(first_blk_nz),
        .dismiss(dismiss), .take(take), .take_level(take_level), .hnd_go(hnd_go),
        .vec_addr(vec_addr), .status(status)
    );

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_lvl(input int dev, input int code);
        lvl_wr_en = 1'b1; lvl_wr_dev = 3'(dev); lvl_wr_code = 3'(code);
        step();
        lvl_wr_en = 1'b0;
    endtask

    task automatic rd_point();
        mem_rd_pt = 1'b1;
        step();
        mem_rd_pt = 1'b0;
    endtask

    task automatic first_word(input bit nz);
        first_done = 1'b1; first_blk_nz = nz;
        step();
        first_done = 1'b0; first_blk_nz = 1'b0;
    endtask

    task automatic do_dismiss();
        dismiss = 1'b1;
        step();
        dismiss = 1'b0;
    endtask

    task automatic t_reset();
        chk(status == 14'd0, "R10 status", status, 0);
        chk(!take && !hnd_go, "R10 strobes", {take, hnd_go}, 0);
    endtask

    task automatic t_assign();
        set_lvl(2, 3);
        dev_req[2] = 1'b1; #1;
        chk(status[6:0] == 7'b0000100, "R1 R9 req level3", status[6:0], 4);
        set_lvl(2, 6); #1;
        chk(status[6:0] == 7'b0100000, "R1 reassign level6", status[6:0], 32);
        set_lvl(2, 3);
    endtask

    task automatic t_disabled();
        dev_req = 8'b0010_0000; #1;
        chk(status == 14'd0, "R2 no request shown", status, 0);
        rd_point();
        chk(!take, "R2 no take at level0", take, 0);
        dev_req = '0;
    endtask

    task automatic t_priority();
        set_lvl(1, 5);
        dev_req = 8'b0000_0110;
        step();
        chk(!take, "R4 no take without read point", take, 0);
        rd_point();
        chk(take && take_level == 3, "R3 level3 wins", take_level, 3);
        chk(vec_addr == 18'd46, "R4 first vector", vec_addr, 46);
        step();
        chk(!take, "R4 take one cycle", take, 0);
        rd_point();
        chk(!take, "R12 read point ignored while waiting", take, 0);
        first_word(1'b0);
        chk(hnd_go && vec_addr == 18'd47, "R8 handler vector", vec_addr, 47);
        chk(status[13:7] == 7'b0000100, "R8 R9 level3 in service", status[13:7], 4);
    endtask

    task automatic t_block_and_preempt();
        rd_point();
        chk(!take, "R5 same/lower level blocked", take, 0);
        set_lvl(4, 1);
        dev_req[4] = 1'b1;
        rd_point();
        chk(take && take_level == 1 && vec_addr == 18'd42, "R5 preempt level1", vec_addr, 42);
        dev_req[4] = 1'b0;
        first_word(1'b1);
        chk(!hnd_go, "R7 no handler jump", hnd_go, 0);
        chk(status[13:7] == 7'b0000100, "R7 level1 cleared", status[13:7], 4);
    endtask

    task automatic t_nest_dismiss();
        set_lvl(6, 2);
        dev_req[6] = 1'b1;
        rd_point();
        chk(take && vec_addr == 18'd44, "R5 nest level2", vec_addr, 44);
        dev_req[6] = 1'b0;
        first_word(1'b0);
        chk(hnd_go && vec_addr == 18'd45, "R8 level2 handler", vec_addr, 45);
        chk(status[13:7] == 7'b0000110, "R9 two in service", status[13:7], 6);
        do_dismiss();
        chk(status[13:7] == 7'b0000100, "R6 only level2 cleared", status[13:7], 4);
    endtask

    task automatic t_level_sensitive();
        do_dismiss();
        chk(status[13:7] == 7'b0, "R6 level3 cleared", status[13:7], 0);
        rd_point();
        chk(take && take_level == 3, "R11 held request retaken", take_level, 3);
        do_dismiss();
        chk(status[13:7] == 7'b0000100, "R12 dismiss ignored while waiting", status[13:7], 4);
        first_word(1'b0);
        do_dismiss();
        dev_req[2] = 1'b0;
        rd_point();
        chk(take && take_level == 5 && vec_addr == 18'd50, "R3 level5 served last", vec_addr, 50);
        first_word(1'b1);
        chk(status[13:7] == 7'b0, "R7 nothing in service", status[13:7], 0);
    endtask

    initial begin
        @(negedge clk); step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_assign();
        t_disabled();
        t_priority();
        t_block_and_preempt();
        t_nest_dismiss();
        t_level_sensitive();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule